// File: doc/BRIEF.md
# Serial DAC Front End

This block is the digital side of a serial-loaded multiplying DAC. A host drives three wires: a serial clock, a serial data line and an active-low frame strobe. The block turns the 16-bit words it receives into commands and updates a parallel DAC code, which it holds on `dac_code` for the converter. A serial output lets several such blocks be chained, and it can also return the current DAC code to the host.

All logic runs on one fast system clock. The serial clock, frame strobe and data line are brought into that domain through two-flop synchronizers, and their edges are detected there. The system clock must therefore run at least four times faster than the serial clock. The serial pins are a fixed wire protocol, so they have no valid/ready handshake and cannot apply back-pressure. `dac_code` is a level: it changes only when a command is acted on and then holds its value.

After reset the block is in chain mode and samples data on falling serial-clock edges. Commands can move it to self-latching single mode and to rising-edge sampling. Each such setting starts with the frame after the one that wrote it.

Top module: `sdac_front`

## Requirements
- R1: After reset, `dac_code` is 0 and `sdo` is 0. Data is sampled on falling `sclk` edges, and chain mode is active.
- R2: A frame is sent MSB first. Bits 15:12 are the command and bits 11:0 are the data field. A register narrower than 12 bits takes the top DATA_BITS bits of the field and ignores the rest.
- R3: Command 4'b0001 copies the data field into `dac_code`.
- R4: Command 4'b1011 sets `dac_code` to zero. Command 4'b1100 sets it to midscale, which is only the top bit set (0x800 at 12 bits, 0x80 at 8 bits).
- R5: Command 4'b0000 and every code not listed in R3, R4, R9, R10 or R12 leaves `dac_code` and all settings unchanged.
- R6: In chain mode, the word in the shift register is acted on at the rising edge of `sync_n`, and never before it. Nothing is acted on if fewer than 16 bits were shifted in that frame.
- R7: In chain mode, bits shifted past the 16th come out on `sdo` MSB first, 16 clock periods after they entered.
- R8: `sdo` changes only on the `sclk` edge opposite to the sampling edge.
- R9: After command 4'b0010, the next frame shifts {4'b0000, dac_code, zero padding to 12 bits} out on `sdo`, MSB first.
- R10: Command 4'b1001 selects single mode from the next frame on. In single mode the word is acted on at the 16th sampling edge, with no rise of `sync_n` needed.
- R11: In single mode, a `sync_n` edge inside a frame of fewer than 16 bits does not restart the count. Bits clocked after the 16th are ignored until a new falling edge of `sync_n`.
- R12: Command 4'b1010 selects rising-edge sampling from the next frame on.
- R13: `sclk` activity while `sync_n` is high shifts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock |
| sync_n | input | 1 | Active-low frame strobe |
| sdin | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (chain pass-through or readback) |
| dac_code | output | DATA_BITS | Current DAC register value |

## Verification
The bench builds two copies of the block, one with the default DATA_BITS of 12 and one with 8, and both share the same serial wires. The 12-bit copy covers the full data field, readback and all mode changes. The 8-bit copy applies the same word stream, so the same words show that the low field bits are dropped and that midscale is derived from the width. Because both copies see every command, they stay in the same mode, and each check can compare either copy against values worked out from the frame.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int WORD_W  = 16;
  localparam int CMD_W   = 4;
  localparam int FIELD_W = WORD_W - CMD_W;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP       = 4'h0,
    CMD_LOAD      = 4'h1,
    CMD_READBACK  = 4'h2,
    CMD_CHAIN_OFF = 4'h9,
    CMD_EDGE_RISE = 4'hA,
    CMD_CLR_ZERO  = 4'hB,
    CMD_CLR_MID   = 4'hC
  } sdac_cmd_e;
endpackage

// File: rtl/sdac_insync.sv
module sdac_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_pin,
  input  logic sync_n_pin,
  input  logic sdin_pin,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sync_low,
  output logic sync_rise,
  output logic sync_fall,
  output logic din
);
  // bit 0: serial clock, bit 1: frame strobe (idle high)
  localparam logic [1:0] IDLE = 2'b10;

  logic [STAGES:0][1:0] ctl_pipe;
  logic [STAGES-1:0]    din_pipe;
  logic [1:0]           now_v, old_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_pipe <= {(STAGES+1){IDLE}};
      din_pipe <= '0;
    end else begin
      ctl_pipe <= {ctl_pipe[STAGES-1:0], {sync_n_pin, sclk_pin}};
      din_pipe <= {din_pipe[STAGES-2:0], sdin_pin};
    end
  end

  assign now_v     = ctl_pipe[STAGES-1];
  assign old_v     = ctl_pipe[STAGES];
  assign sclk_rise = now_v[0] & ~old_v[0];
  assign sclk_fall = ~now_v[0] & old_v[0];
  assign sync_low  = ~now_v[1];
  assign sync_rise = now_v[1] & ~old_v[1];
  assign sync_fall = ~now_v[1] & old_v[1];
  assign din       = din_pipe[STAGES-1];
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift
  import sdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sync_low,
  input  logic              sync_rise,
  input  logic              sync_fall,
  input  logic              din,
  input  logic              live_rise,
  input  logic              live_chain,
  input  logic              rb_pend,
  input  logic [WORD_W-1:0] rb_word,
  output logic              sdo,
  output logic              out_edge,
  output logic              frame_start,
  output logic              exec_vld,
  output logic [WORD_W-1:0] exec_word
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sreg, sreg_nx;
  logic [CNT_W-1:0]  cnt;
  logic              open_q;
  logic              act_edge, start_ok, shift_ok;

  assign act_edge = live_rise ? sclk_rise : sclk_fall;
  assign out_edge = (live_rise ? sclk_fall : sclk_rise) & sync_low & open_q;
  // single mode: a strobe edge inside a partial frame is ignored
  assign start_ok = sync_fall & ~(~live_chain & open_q & (cnt != '0));
  assign shift_ok = open_q & sync_low & act_edge;
  assign sreg_nx  = {sreg[WORD_W-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg        <= '0;
      cnt         <= '0;
      open_q      <= 1'b0;
      sdo         <= 1'b0;
      frame_start <= 1'b0;
      exec_vld    <= 1'b0;
      exec_word   <= '0;
    end else begin
      frame_start <= 1'b0;
      exec_vld    <= 1'b0;
      if (start_ok) begin
        cnt         <= '0;
        open_q      <= 1'b1;
        frame_start <= 1'b1;
        if (rb_pend) sreg <= rb_word;
      end else if (shift_ok) begin
        sreg <= sreg_nx;
        if (cnt != FULL) cnt <= cnt + 1'b1;
        if (!live_chain && cnt == LAST) begin
          exec_vld  <= 1'b1;
          exec_word <= sreg_nx;
          open_q    <= 1'b0;
        end
      end else if (open_q && sync_rise && live_chain) begin
        open_q <= 1'b0;
        if (cnt == FULL) begin
          exec_vld  <= 1'b1;
          exec_word <= sreg;
        end
      end
      if (out_edge) sdo <= sreg[WORD_W-1];
    end
  end
endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
  import sdac_pkg::*;
#(
  parameter int DATA_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 exec_vld,
  input  logic [WORD_W-1:0]    exec_word,
  input  logic                 frame_start,
  output logic [DATA_BITS-1:0] dac_code,
  output logic                 live_rise,
  output logic                 live_chain,
  output logic                 rb_pend,
  output logic [WORD_W-1:0]    rb_word
);
  localparam int PAD_W = FIELD_W - DATA_BITS;
  localparam logic [DATA_BITS-1:0] MID = {1'b1, {(DATA_BITS-1){1'b0}}};

  logic                 pend_rise, pend_single;
  logic [DATA_BITS-1:0] field;
  sdac_cmd_e            cmd;

  assign cmd     = sdac_cmd_e'(exec_word[WORD_W-1 -: CMD_W]);
  assign field   = exec_word[FIELD_W-1 -: DATA_BITS];
  assign rb_word = WORD_W'(dac_code) << PAD_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code    <= '0;
      pend_rise   <= 1'b0;
      pend_single <= 1'b0;
      live_rise   <= 1'b0;
      live_chain  <= 1'b1;
      rb_pend     <= 1'b0;
    end else if (frame_start) begin
      live_rise  <= pend_rise;
      live_chain <= ~pend_single;
      rb_pend    <= 1'b0;
    end else if (exec_vld) begin
      case (cmd)
        CMD_LOAD:      dac_code    <= field;
        CMD_READBACK:  rb_pend     <= 1'b1;
        CMD_CHAIN_OFF: pend_single <= 1'b1;
        CMD_EDGE_RISE: pend_rise   <= 1'b1;
        CMD_CLR_ZERO:  dac_code    <= '0;
        CMD_CLR_MID:   dac_code    <= MID;
        default:       ;
      endcase
    end
  end
endmodule

// File: rtl/sdac_front.sv
module sdac_front
  import sdac_pkg::*;
#(
  parameter int DATA_BITS   = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk,
  input  logic                 sync_n,
  input  logic                 sdin,
  output logic                 sdo,
  output logic [DATA_BITS-1:0] dac_code
);
  logic              sclk_rise, sclk_fall, sync_low, sync_rise, sync_fall, din;
  logic              live_rise, live_chain, rb_pend;
  logic              out_edge, frame_start, exec_vld;
  logic [WORD_W-1:0] rb_word, exec_word;

  sdac_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_pin(sclk), .sync_n_pin(sync_n),
    .sdin_pin(sdin), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .sync_low(sync_low), .sync_rise(sync_rise), .sync_fall(sync_fall),
    .din(din)
  );

  sdac_shift u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .sync_low(sync_low), .sync_rise(sync_rise), .sync_fall(sync_fall),
    .din(din), .live_rise(live_rise), .live_chain(live_chain),
    .rb_pend(rb_pend), .rb_word(rb_word), .sdo(sdo), .out_edge(out_edge),
    .frame_start(frame_start), .exec_vld(exec_vld), .exec_word(exec_word)
  );

  sdac_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .exec_vld(exec_vld), .exec_word(exec_word),
    .frame_start(frame_start), .dac_code(dac_code), .live_rise(live_rise),
    .live_chain(live_chain), .rb_pend(rb_pend), .rb_word(rb_word)
  );
endmodule

// File: rtl/sdac_chk.sv
module sdac_chk #(
  parameter int DATA_BITS = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [DATA_BITS-1:0] dac_code,
  input logic                 sdo,
  input logic                 out_edge,
  input logic                 exec_vld,
  input logic [3:0]           exec_cmd,
  input logic                 frame_start,
  input logic                 live_rise,
  input logic                 live_chain
);
  localparam logic [DATA_BITS-1:0] MID = {1'b1, {(DATA_BITS-1){1'b0}}};

  // R3
  dac_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code) |-> $past(exec_vld));
  // R4
  midscale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_vld && exec_cmd == 4'hC) |=> (dac_code == MID));
  // R8
  sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(out_edge));
  // R12
  edge_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(live_rise) |-> $past(frame_start));
  // R10
  mode_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(live_chain) |-> $past(frame_start));
  // R6
  exec_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_vld && frame_start));
endmodule

bind sdac_front sdac_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .dac_code(dac_code), .sdo(sdo),
  .out_edge(out_edge), .exec_vld(exec_vld), .exec_cmd(exec_word[15:12]),
  .frame_start(frame_start), .live_rise(live_rise), .live_chain(live_chain)
);

// File: tb/tb_sdac_front.sv
module tb_sdac_front;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sync_n = 1'b1, sdin = 1'b0;
  logic sdo, sdo8;
  logic [11:0] dac;
  logic [7:0]  dac8;
  logic [31:0] cap = '0;
  logic        rise_mode = 1'b0;
  int n_chk = 0, n_fail = 0;
  localparam int H = 6;

  always #2.5 clk = ~clk;

  sdac_front dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n),
                  .sdin(sdin), .sdo(sdo), .dac_code(dac));
  sdac_front #(.DATA_BITS(8)) dut8 (.clk(clk), .rst_n(rst_n), .sclk(sclk),
                  .sync_n(sync_n), .sdin(sdin), .sdo(sdo8), .dac_code(dac8));

  // {word, 12-bit result, 8-bit result}, chain mode, falling edge
  localparam logic [35:0] VECS [9] = '{
    {16'h1ABC, 12'hABC, 8'hAB}, {16'hB123, 12'h000, 8'h00},
    {16'h1555, 12'h555, 8'h55}, {16'hC000, 12'h800, 8'h80},
    {16'h0FFF, 12'h800, 8'h80}, {16'h3FFF, 12'h800, 8'h80},
    {16'h1FFF, 12'hFFF, 8'hFF}, {16'hE001, 12'hFFF, 8'hFF},
    {16'h1001, 12'h001, 8'h00}};

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] bits, input int n, input bit fall, input bit raise);
    if (fall) begin sync_n = 1'b0; wt(H); end
    for (int i = 0; i < n; i++) begin
      sclk = ~rise_mode;
      sdin = bits[n-1-i];
      wt(H);
      cap = {cap[30:0], sdo};
      sclk = rise_mode;
      wt(H);
    end
    wt(H);
    if (raise) begin sync_n = 1'b1; wt(10); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wt(10); rst_n = 1'b1; wt(5);
    chk("R1 dac", 32'(dac), 0);
    chk("R1 sdo", 32'(sdo), 0);
    chk("R1 dac8", 32'(dac8), 0);
    // R13: clocking with the strobe high must shift nothing
    for (int i = 0; i < 20; i++) begin
      sdin = 1'b1; sclk = 1'b1; wt(3); sclk = 1'b0; wt(3);
    end
    send({16'h1234, 16'h1321}, 32, 1, 1);
    chk("R13 stale sdo", 32'(cap[31:16]), 0);
    chk("R7 pass-through", 32'(cap[15:0]), 32'h1234);
    chk("R6 last word", 32'(dac), 32'h321);
    send(32'h1777, 16, 1, 0);
    chk("R6 before rise", 32'(dac), 32'h321);
    sync_n = 1'b1; wt(10);
    chk("R6 at rise", 32'(dac), 32'h777);
    send(32'h00FF, 8, 1, 1);
    chk("R6 short frame", 32'(dac), 32'h777);
    // table walk: R2 R3 R4 R5
    for (int k = 0; k < 9; k++) begin
      send(32'(VECS[k][35:20]), 16, 1, 1);
      chk("R3/R4/R5 table", 32'(dac), 32'(VECS[k][19:8]));
      chk("R2 narrow table", 32'(dac8), 32'(VECS[k][7:0]));
    end
    // R9 readback, R8 timing on rising out edges
    send(32'h1A5C, 16, 1, 1);
    send(32'h2000, 16, 1, 1);
    chk("R5 readback cmd keeps dac", 32'(dac), 32'hA5C);
    send(32'h0000, 16, 1, 1);
    chk("R9 R8 readback falling", 32'(cap[15:0]), 32'h0A5C);
    // R10 single mode from next frame
    send(32'h9000, 16, 1, 1);
    chk("R10 cmd frame", 32'(dac), 32'hA5C);
    send(32'h1321, 16, 1, 0);
    chk("R10 self latch", 32'(dac), 32'h321);
    sync_n = 1'b1; wt(10);
    // R11 strobe glitch mid frame, then extra bits
    send(32'(6'b000101), 6, 1, 0);
    sync_n = 1'b1; wt(H); sync_n = 1'b0; wt(H);
    chk("R11 partial", 32'(dac), 32'h321);
    send(32'(10'h254), 10, 0, 0);
    chk("R11 glitch ignored", 32'(dac), 32'h654);
    send(32'h1111, 16, 0, 1);
    chk("R11 extra bits", 32'(dac), 32'h654);
    // R12 rising sampling from next frame
    send(32'hA000, 16, 1, 1);
    rise_mode = 1'b1; sclk = 1'b1; wt(H);
    send(32'h1BEE, 16, 1, 1);
    chk("R12 rising load", 32'(dac), 32'hBEE);
    chk("R2 narrow rising", 32'(dac8), 32'hBE);
    send(32'h2000, 16, 1, 1);
    send(32'h0000, 16, 1, 1);
    chk("R9 R8 readback rising", 32'(cap[15:0]), 32'h0BEE);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule